// File: doc/BRIEF.md
# Compressor Column-Reduction Multiplier (8x8 unsigned)

This block multiplies two 8-bit unsigned operands and returns the full 16-bit product. It is purely combinational: the product follows the operands within the same evaluation, with no clock, no reset and no handshake. Its only purpose is to be a fast multiply path inside a larger datapath.

Internally, the operands are split into low and high nibbles. Each of the four nibble pairs forms a 4x4 partial-product array. Every column of that array is collapsed by one 4:2 compressor. The four nibble products then arrive as two rows each. Their columns are collapsed by one 7:2 compressor per product column, and the 7:2 cell is itself built from two 4:2 cells. Every compressor passes its outgoing carries only to the next more significant column, so carries never chain along a reduction row. One carry-propagate addition of the three remaining rows yields the product.

Top module: `colcomp_mul`

## Requirements
- R1: The 4:2 compressor satisfies x1+x2+x3+x4+cin = sum + 2*(carry + cout) for all 32 input combinations.
- R2: The 4:2 compressor's cout equals the majority of x1, x2 and x3, and never depends on cin.
- R3: The 7:2 compressor satisfies bits[0]+...+bits[6]+cin_a+cin_b = sum + 2*(carry_lo + carry_hi + cout_a + cout_b) for all 512 input combinations.
- R4: In the 7:2 compressor, cout_a depends on neither incoming carry, and cout_b does not depend on cin_b, so an incoming carry influences outgoing carries at most one column further.
- R5: The 4x4 nibble multiplier returns two 8-bit rows whose sum, sum_row + carry_row, equals a*b for all 256 nibble pairs, and bit 0 of carry_row is always 0.
- R6: product equals op_a*op_b for every one of the 65536 operand pairs.
- R7: Boundary operands give exact results: any operand 0 gives 0, 0xFF*0xFF gives 0xFE01 (the largest product, with bit 15 set), and 1*x gives x.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 8 | Unsigned multiplicand |
| op_b | input | 8 | Unsigned multiplier |
| product | output | 16 | Unsigned product op_a*op_b |

## Verification
The cells are driven exhaustively on their own, before the full multiplier is tested. A 4:2 cell that swapped the roles of the two multiplexer data inputs would break the weighted-sum identity for only a few input patterns. A carry output tied to cin would break independence from cin, and cells carrying such a fault would then ripple along a row. The 7:2 independence check toggles each incoming carry while the seven data bits are held, which catches a cell wired so that cin_a reaches cout_b's sibling outputs the wrong way. All 65536 operand pairs and the all-ones corner expose any column whose outgoing carry is dropped or fed to the wrong column. Such a fault shows up as products off by a power of two, mostly where the column sums are highest (middle bits, large operands).

// File: rtl/colcomp_pkg.sv
// Shared sizes for the compressor column-reduction multiplier.
// Assumes an 8-bit operand width: the 4:2 and 7:2 cell fan-ins are
// matched to the column heights that width produces.
package colcomp_pkg;
    localparam int OP_W     = 8;
    localparam int HALF_W   = OP_W / 2;
    localparam int PROD_W   = 2 * OP_W;
    localparam int NIB_PW   = 2 * HALF_W;
    localparam int C72_IN   = 7;
    localparam int MERGE_RW = 6;
endpackage

// File: rtl/colcomp_cmp42.sv
// Modified 4:2 compressor: five equal-weight bits in, one weight-1 and
// two weight-2 bits out. XOR stages are partly replaced by 2:1 muxes;
// cout is taken from x1..x3 only, so it never waits on cin.
module colcomp_cmp42 (
    input  logic x1,
    input  logic x2,
    input  logic x3,
    input  logic x4,
    input  logic cin,
    output logic sum,
    output logic carry,
    output logic cout
);
    logic par12;
    logic par34;
    logic par_all;

    // Parity terms and mux-selected carries.
    always_comb begin
        par12   = x1 ^ x2;
        par34   = x3 ^ x4;
        par_all = par12 ^ par34;
        cout    = par12 ? x3 : x1;
        sum     = par_all ^ cin;
        carry   = par_all ? cin : x4;
    end

    // Guard the counting identity and the cin-free outgoing carry.
    always_comb begin
        // R1
        weight42_chk: assert (int'(x1) + int'(x2) + int'(x3) + int'(x4) + int'(cin)
                              == int'(sum) + 2 * (int'(carry) + int'(cout)))
            else $error("4:2 weighted sum mismatch");
        // R2
        cout_maj_chk: assert (cout == ((int'(x1) + int'(x2) + int'(x3)) >= 2))
            else $error("4:2 cout not majority of x1..x3");
    end
endmodule

// File: rtl/colcomp_cmp72.sv
// 7:2 compressor from two modified 4:2 cells. Nine equal-weight bits in
// (seven data, two carries from the column below); one weight-1 bit and
// four weight-2 bits out. cout_a sees only data bits; cout_b sees data
// bits and cin_a, never cin_b.
module colcomp_cmp72
    import colcomp_pkg::*;
(
    input  logic [C72_IN-1:0] bits,
    input  logic              cin_a,
    input  logic              cin_b,
    output logic              sum,
    output logic              carry_lo,
    output logic              carry_hi,
    output logic              cout_a,
    output logic              cout_b
);
    logic mid_sum;

    colcomp_cmp42 u_first (
        .x1(bits[0]), .x2(bits[1]), .x3(bits[2]), .x4(bits[3]),
        .cin(cin_a), .sum(mid_sum), .carry(carry_lo), .cout(cout_a)
    );

    colcomp_cmp42 u_second (
        .x1(mid_sum), .x2(bits[4]), .x3(bits[5]), .x4(bits[6]),
        .cin(cin_b), .sum(sum), .carry(carry_hi), .cout(cout_b)
    );

    // Guard the nine-input counting identity.
    always_comb begin
        // R3
        weight72_chk: assert ($countones(bits) + int'(cin_a) + int'(cin_b)
                              == int'(sum) + 2 * (int'(carry_lo) + int'(carry_hi)
                                                  + int'(cout_a) + int'(cout_b)))
            else $error("7:2 weighted sum mismatch");
    end
endmodule

// File: rtl/colcomp_nib.sv
// 4x4 nibble multiplier: one 4:2 compressor per column of the AND array.
// Each column's cout feeds the next column's cin only. Output is two rows
// (sum_row, carry_row) whose sum is the nibble product.
module colcomp_nib
    import colcomp_pkg::*;
#(
    parameter int NW = HALF_W
) (
    input  logic [NW-1:0]   a,
    input  logic [NW-1:0]   b,
    output logic [2*NW-1:0] sum_row,
    output logic [2*NW-1:0] carry_row
);
    localparam int NCOL = 2 * NW;

    logic [NW-1:0]   col_bits [NCOL];
    logic [NCOL-1:0] col_sum;
    logic [NCOL-1:0] col_carry;
    logic [NCOL-1:0] col_cout;

    // Place each AND term a[i]&b[j] in column i+j, slot i.
    always_comb begin
        for (int k = 0; k < NCOL; k++) begin
            col_bits[k] = '0;
            for (int i = 0; i < NW; i++) begin
                if ((k - i) >= 0 && (k - i) < NW)
                    col_bits[k][i] = a[i] & b[k-i];
            end
        end
    end

    for (genvar k = 0; k < NCOL; k++) begin : g_col
        logic cin_k;
        if (k == 0) begin : g_first
            assign cin_k = 1'b0;
        end else begin : g_rest
            assign cin_k = col_cout[k-1];
        end
        colcomp_cmp42 u_c42 (
            .x1(col_bits[k][0]), .x2(col_bits[k][1]),
            .x3(col_bits[k][2]), .x4(col_bits[k][3]),
            .cin(cin_k), .sum(col_sum[k]),
            .carry(col_carry[k]), .cout(col_cout[k])
        );
    end

    // Weight-2 outputs of column k land in column k+1.
    always_comb begin
        sum_row   = col_sum;
        carry_row = {col_carry[NCOL-2:0], 1'b0};
    end

    // Guard the two-row result and the empty top-column carries.
    always_comb begin
        // R5
        nib_rows_chk: assert (int'(sum_row) + int'(carry_row) == int'(a) * int'(b))
            else $error("nibble rows do not sum to product");
        // R5
        nib_top_zero_chk: assert (col_carry[NCOL-1] == 1'b0 && col_cout[NCOL-1] == 1'b0)
            else $error("nibble top column emitted a carry");
    end
endmodule

// File: rtl/colcomp_mul.sv
// Top: 8x8 unsigned combinational multiplier. Four nibble products (4:2
// reduction) give eight rows; the low-low and high-high rows never share
// a column, so they merge, leaving six rows. One 7:2 compressor per
// column reduces them to three rows, and a single carry-propagate
// addition forms the product.
module colcomp_mul
    import colcomp_pkg::*;
(
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    output logic [PROD_W-1:0] product
);
    logic [NIB_PW-1:0] nib_sum [4];
    logic [NIB_PW-1:0] nib_car [4];
    logic [PROD_W-1:0] mrow    [MERGE_RW];
    logic [PROD_W-1:0] red_sum;
    logic [PROD_W-1:0] red_lo;
    logic [PROD_W-1:0] red_hi;
    logic [PROD_W-1:0] red_couta;
    logic [PROD_W-1:0] red_coutb;

    // Quadrant q: bit0 picks the op_a nibble, bit1 the op_b nibble.
    for (genvar q = 0; q < 4; q++) begin : g_nib
        localparam int AOFF = (q % 2) * HALF_W;
        localparam int BOFF = (q / 2) * HALF_W;
        colcomp_nib #(.NW(HALF_W)) u_nib (
            .a(op_a[AOFF +: HALF_W]),
            .b(op_b[BOFF +: HALF_W]),
            .sum_row(nib_sum[q]),
            .carry_row(nib_car[q])
        );
    end

    // Align nibble rows to their weight; merge low-low with high-high.
    always_comb begin
        mrow[0] = {nib_sum[3], nib_sum[0]};
        mrow[1] = {nib_car[3], nib_car[0]};
        mrow[2] = PROD_W'(nib_sum[1]) << HALF_W;
        mrow[3] = PROD_W'(nib_car[1]) << HALF_W;
        mrow[4] = PROD_W'(nib_sum[2]) << HALF_W;
        mrow[5] = PROD_W'(nib_car[2]) << HALF_W;
    end

    for (genvar k = 0; k < PROD_W; k++) begin : g_col
        logic [C72_IN-1:0] cbits;
        logic              cin_a_k;
        logic              cin_b_k;
        // Gather this column's six row bits; seventh slot unused.
        always_comb begin
            cbits = '0;
            for (int r = 0; r < MERGE_RW; r++)
                cbits[r] = mrow[r][k];
        end
        if (k == 0) begin : g_first
            assign cin_a_k = 1'b0;
            assign cin_b_k = 1'b0;
        end else begin : g_rest
            assign cin_a_k = red_couta[k-1];
            assign cin_b_k = red_coutb[k-1];
        end
        colcomp_cmp72 u_c72 (
            .bits(cbits), .cin_a(cin_a_k), .cin_b(cin_b_k),
            .sum(red_sum[k]), .carry_lo(red_lo[k]), .carry_hi(red_hi[k]),
            .cout_a(red_couta[k]), .cout_b(red_coutb[k])
        );
    end

    // Final carry-propagate addition of the three reduced rows.
    always_comb begin
        product = red_sum + {red_lo[PROD_W-2:0], 1'b0} + {red_hi[PROD_W-2:0], 1'b0};
    end

    // Guard the end result and the top column's dropped outputs.
    always_comb begin
        // R6
        product_chk: assert (int'(product) == int'(op_a) * int'(op_b))
            else $error("product mismatch");
        // R6
        top_col_zero_chk: assert (red_lo[PROD_W-1] == 1'b0 && red_hi[PROD_W-1] == 1'b0
                                  && red_couta[PROD_W-1] == 1'b0
                                  && red_coutb[PROD_W-1] == 1'b0)
            else $error("top column emitted a carry");
    end
endmodule

// File: tb/colcomp_mul_bench.sv
module colcomp_mul_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam int N_RANDOM   = 2000;

    logic clk = 1'b0;
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Cell under test: 4:2
    logic [3:0] c4_x;
    logic       c4_cin, c4_sum, c4_carry, c4_cout;
    colcomp_cmp42 u_cmp42 (
        .x1(c4_x[0]), .x2(c4_x[1]), .x3(c4_x[2]), .x4(c4_x[3]),
        .cin(c4_cin), .sum(c4_sum), .carry(c4_carry), .cout(c4_cout)
    );

    // Cell under test: 7:2
    logic [6:0] c7_bits;
    logic       c7_cina, c7_cinb, c7_sum, c7_lo, c7_hi, c7_couta, c7_coutb;
    colcomp_cmp72 u_cmp72 (
        .bits(c7_bits), .cin_a(c7_cina), .cin_b(c7_cinb), .sum(c7_sum),
        .carry_lo(c7_lo), .carry_hi(c7_hi), .cout_a(c7_couta), .cout_b(c7_coutb)
    );

    // Nibble multiplier
    logic [3:0] nb_a, nb_b;
    logic [7:0] nb_sum, nb_car;
    colcomp_nib #(.NW(4)) u_nib (
        .a(nb_a), .b(nb_b), .sum_row(nb_sum), .carry_row(nb_car)
    );

    // Top
    logic [7:0]  op_a, op_b;
    logic [15:0] product;
    colcomp_mul u_colcomp_mul (.op_a(op_a), .op_b(op_b), .product(product));

    function automatic int exp_mul(input int a, input int b);
        return a * b;
    endfunction

    function automatic int maj3(input logic [3:0] x);
        return ((int'(x[0]) + int'(x[1]) + int'(x[2])) >= 2) ? 1 : 0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic run_top(input int a, input int b, input string req);
        @(negedge clk);
        op_a = 8'(a);
        op_b = 8'(b);
        #(CLK_PERIOD/4);
        check(req, int'(product), exp_mul(a, b));
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        c4_x = '0; c4_cin = 1'b0;
        c7_bits = '0; c7_cina = 1'b0; c7_cinb = 1'b0;
        nb_a = '0; nb_b = '0;
        op_a = '0; op_b = '0;
        settle();
        // R7: idle operands give a zero product
        check("R7 zero at start", int'(product), 0);

        // R1, R2: exhaustive 4:2
        for (int v = 0; v < 32; v++) begin
            @(negedge clk);
            c4_x   = 4'(v);
            c4_cin = v[4];
            #(CLK_PERIOD/4);
            check("R1 4:2 identity", int'(c4_sum) + 2 * (int'(c4_carry) + int'(c4_cout)),
                  $countones(v[4:0]));
            check("R2 4:2 cout majority", int'(c4_cout), maj3(4'(v)));
        end

        // R3, R4: exhaustive 7:2 with carry independence
        for (int x = 0; x < 128; x++) begin
            int ref_a, ref_b0, ref_b1;
            ref_a = 0; ref_b0 = 0; ref_b1 = 0;
            for (int c = 0; c < 4; c++) begin
                @(negedge clk);
                c7_bits = 7'(x);
                c7_cina = c[0];
                c7_cinb = c[1];
                #(CLK_PERIOD/4);
                check("R3 7:2 identity",
                      int'(c7_sum) + 2 * (int'(c7_lo) + int'(c7_hi) + int'(c7_couta) + int'(c7_coutb)),
                      $countones(x[6:0]) + c[0] + c[1]);
                if (c == 0) begin
                    ref_a  = int'(c7_couta);
                    ref_b0 = int'(c7_coutb);
                end else if (c == 1) begin
                    ref_b1 = int'(c7_coutb);
                end
                check("R4 cout_a free of cin", int'(c7_couta), ref_a);
                if (c == 2) check("R4 cout_b free of cin_b", int'(c7_coutb), ref_b0);
                if (c == 3) check("R4 cout_b free of cin_b", int'(c7_coutb), ref_b1);
            end
        end

        // R5: exhaustive nibble multiplier
        for (int v = 0; v < 256; v++) begin
            @(negedge clk);
            nb_a = 4'(v);
            nb_b = 4'(v >> 4);
            #(CLK_PERIOD/4);
            check("R5 nibble rows", int'(nb_sum) + int'(nb_car), exp_mul(v % 16, v / 16));
            check("R5 carry_row bit0", int'(nb_car[0]), 0);
        end

        // R7: directed corners
        run_top(255, 255, "R7 max*max");
        check("R7 max product bit15", int'(product[15]), 1);
        run_top(0, 255, "R7 zero*max");
        run_top(255, 0, "R7 max*zero");
        run_top(1, 173, "R7 one*x");
        run_top(128, 128, "R7 msb*msb");
        run_top(255, 1, "R7 max*one");

        // R6: fixed-seed random pairs
        void'($urandom(32'd20240611));
        for (int i = 0; i < N_RANDOM; i++)
            run_top(int'($urandom % 256), int'($urandom % 256), "R6 random");

        // R6: every operand pair
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                run_top(a, b, "R6 exhaustive");

        done = 1'b1;
        summary();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
            summary();
        end
    end
endmodule